// File: doc/BRIEF.md
# Packet Transceiver SPI Command Port

This block is the host-facing command port of a sub-GHz packet radio. A host CPU talks to it as an SPI slave in mode 0, most significant bit first. Each transaction is framed by the active-low chip select. The first byte of a frame is an opcode, and while it shifts in the block returns a status byte. The opcode then picks what the rest of the frame does. It can stream into or out of a ten-byte configuration file with an auto-incrementing address. It can stream through the TX payload buffer, the TX address buffer or the RX payload buffer. It can also apply a compact channel setting.

The SPI pins are brought into the block clock domain through synchronizer flops, so SCLK must run well below the block clock. The RX payload buffer is filled from a byte stream port with valid/ready handshaking. A byte moves when both `rx_load_valid` and `rx_load_ready` are high at a rising clock edge. The block lowers ready for as long as a synchronized chip select is active, so loading never collides with an SPI read. Each accepted byte goes to the next RX slot, and the slot index wraps at the buffer depth. The two status flags are plain level inputs.

Top module: `radio_spi_cmd`

## Requirements
- R1: MISO returns the status byte during the opcode byte: bit 7 is `flag_addr_match`, bit 5 is `flag_data_ready`, and every other bit is 0. The flags are captured when chip select is recognized low.
- R2: An opcode 0x00–0x0F writes configuration. The low nibble is the start address, and each following MOSI byte is stored at the next address.
- R3: An opcode 0x10–0x1F reads configuration. Each byte time after the opcode returns the configuration byte at the low-nibble address, and the address then increments.
- R4: Configuration addresses run from 0 to 9. Writes aimed at address 10 or above are dropped, and reads there return 0. This includes frames whose start address is above 9.
- R5: An opcode 0x80–0x8F is a channel setting. Opcode bits 3:0 replace bits 3:0 of configuration byte 1, and bits 7:4 of that byte are kept. The first data byte replaces configuration byte 0, and any further data bytes are ignored.
- R6: Opcode 0x20 writes and opcode 0x21 reads the TX payload buffer (PAY_DEPTH bytes) from index 0. The index wraps to 0 after the last slot.
- R7: Opcode 0x22 writes and opcode 0x23 reads the TX address buffer (TXA_DEPTH bytes) from index 0. The index wraps to 0 after the last slot.
- R8: Opcode 0x24 reads the RX payload buffer from index 0, and the index wraps. The buffer is filled only through the load stream. `rx_load_ready` is low while chip select is active, and a load offered then is not taken.
- R9: Any other opcode leaves all storage unchanged and returns 0 after the status byte. MISO also returns 0 during the data bytes of every write and channel frame.
- R10: Raising chip select ends the frame at once and discards any partial byte. The next frame starts again with an opcode.
- R11: After reset, every configuration byte is 0, MISO is 0 and `rx_load_ready` is 1. MISO stays 0 while chip select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| flag_addr_match | input | 1 | Address-match status flag |
| flag_data_ready | input | 1 | Data-ready status flag |
| rx_load_valid | input | 1 | RX load stream byte valid |
| rx_load_ready | output | 1 | RX load stream ready (low during a frame) |
| rx_load_data | input | 8 | RX load stream byte |

## Verification
The bench uses the default depths: a 32-byte payload and a 4-byte TX address buffer. With these depths, frames of a few dozen bytes run past the end of every buffer. Each wrap point is therefore exercised against a model, as is the saturation of the configuration address beyond byte 9. The synchronizer depth stays at two, and SCLK runs at one sixteenth of the block clock. At that ratio every next-byte fetch is ready well before the SCLK falling edge that loads it.

// File: rtl/radio_spi_pkg.sv
package radio_spi_pkg;

  localparam int CFG_BYTES   = 10;
  localparam int CHAN_LO_IDX = 0;
  localparam int CHAN_HI_IDX = 1;

  localparam logic [7:0] OP_TXP_WR = 8'h20;
  localparam logic [7:0] OP_TXP_RD = 8'h21;
  localparam logic [7:0] OP_TXA_WR = 8'h22;
  localparam logic [7:0] OP_TXA_RD = 8'h23;
  localparam logic [7:0] OP_RXP_RD = 8'h24;

  typedef enum logic [3:0] {
    M_CMD,
    M_CFG_WR,
    M_CFG_RD,
    M_TXP_WR,
    M_TXP_RD,
    M_TXA_WR,
    M_TXA_RD,
    M_RXP_RD,
    M_CHAN,
    M_DONE
  } cmd_mode_e;

  function automatic cmd_mode_e decode_op(input logic [7:0] op);
    cmd_mode_e m;
    if (op[7:4] == 4'h0)      m = M_CFG_WR;
    else if (op[7:4] == 4'h1) m = M_CFG_RD;
    else if (op[7:4] == 4'h8) m = M_CHAN;
    else if (op == OP_TXP_WR) m = M_TXP_WR;
    else if (op == OP_TXP_RD) m = M_TXP_RD;
    else if (op == OP_TXA_WR) m = M_TXA_WR;
    else if (op == OP_TXA_RD) m = M_TXA_RD;
    else if (op == OP_RXP_RD) m = M_RXP_RD;
    else                      m = M_DONE;
    return m;
  endfunction

endpackage

// File: rtl/radio_spi_byte_port.sv
module radio_spi_byte_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] status_byte,
  input  logic [7:0] tx_byte,
  output logic       active,
  output logic       frame_start,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);

  logic [SYNC_STAGES-1:0] sclk_s, cs_s, mosi_s;
  logic sclk_d, cs_d;
  logic [2:0] bit_cnt;
  logic [7:0] in_sh, out_sh;

  logic sclk_now, cs_now, mosi_now, rise, fall;
  assign sclk_now = sclk_s[SYNC_STAGES-1];
  assign cs_now   = cs_s[SYNC_STAGES-1];
  assign mosi_now = mosi_s[SYNC_STAGES-1];
  assign rise     = sclk_now & ~sclk_d;
  assign fall     = ~sclk_now & sclk_d;

  assign active      = ~cs_now;
  assign frame_start = ~cs_now & cs_d;
  assign miso        = out_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[SYNC_STAGES-2:0], sclk};
      cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_n};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
      sclk_d <= sclk_now;
      cs_d   <= cs_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      in_sh     <= '0;
      out_sh    <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (cs_now) begin
        bit_cnt <= '0;
        out_sh  <= '0;
      end else if (frame_start) begin
        bit_cnt <= '0;
        out_sh  <= status_byte;
      end else begin
        if (rise) begin
          in_sh   <= {in_sh[6:0], mosi_now};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {in_sh[6:0], mosi_now};
          end
        end
        if (fall) begin
          if (bit_cnt == 3'd0) out_sh <= tx_byte;
          else                 out_sh <= {out_sh[6:0], 1'b0};
        end
      end
    end
  end

  assert_miso_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_now && cs_d) |-> !miso);

  assert_status_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (miso == $past(status_byte[7])));

endmodule

// File: rtl/radio_cfg_file.sv
module radio_cfg_file
  import radio_spi_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              chan_en,
  input  logic [3:0]        chan_bits,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int FLAT_W = CFG_BYTES * 8;

  logic [7:0] regs_q [CFG_BYTES];
  logic [FLAT_W-1:0] flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CFG_BYTES; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < CFG_BYTES; i++)
        if (wr_en && wr_addr == ADDR_W'(i)) regs_q[i] <= wr_data;
      if (chan_en) regs_q[CHAN_HI_IDX][3:0] <= chan_bits;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < CFG_BYTES; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs_q[i];
  end

  always_comb begin
    for (int i = 0; i < CFG_BYTES; i++) flat[i*8 +: 8] = regs_q[i];
  end

  assert_drop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !chan_en && wr_addr >= ADDR_W'(CFG_BYTES)) |=> $stable(flat));

  assert_chan_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !wr_en) |=>
      (flat[CHAN_HI_IDX*8 +: 4] == $past(chan_bits)) &&
      (flat[CHAN_HI_IDX*8+4 +: 4] == $past(flat[CHAN_HI_IDX*8+4 +: 4])));

endmodule

// File: rtl/radio_byte_ram.sv
module radio_byte_ram #(
  parameter int DEPTH = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/radio_spi_cmd.sv
module radio_spi_cmd
  import radio_spi_pkg::*;
#(
  parameter int PAY_DEPTH   = 32,
  parameter int TXA_DEPTH   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic       flag_addr_match,
  input  logic       flag_data_ready,
  input  logic       rx_load_valid,
  output logic       rx_load_ready,
  input  logic [7:0] rx_load_data
);

  localparam int PAY_IW = $clog2(PAY_DEPTH);
  localparam int TXA_IW = $clog2(TXA_DEPTH);
  localparam int BIG_IW = (PAY_IW > TXA_IW) ? PAY_IW : TXA_IW;
  localparam int PTR_W  = (BIG_IW > 5) ? BIG_IW : 5;

  logic       active, frame_start, byte_done;
  logic [7:0] rx_byte, tx_byte, status_byte;

  assign status_byte = {flag_addr_match, 1'b0, flag_data_ready, 5'b0};

  radio_spi_byte_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (spi_sclk),
    .cs_n       (spi_cs_n),
    .mosi       (spi_mosi),
    .status_byte(status_byte),
    .tx_byte    (tx_byte),
    .active     (active),
    .frame_start(frame_start),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .miso       (spi_miso)
  );

  cmd_mode_e        mode_q, op_mode;
  logic [PTR_W-1:0] ptr_q, ptr_inc;
  logic [PAY_IW-1:0] rx_wptr;
  logic cmd_phase, data_phase;

  assign op_mode    = decode_op(rx_byte);
  assign cmd_phase  = byte_done && (mode_q == M_CMD);
  assign data_phase = byte_done && (mode_q != M_CMD);

  always_comb begin
    case (mode_q)
      M_CFG_WR, M_CFG_RD:
        ptr_inc = (ptr_q >= PTR_W'(CFG_BYTES)) ? ptr_q : ptr_q + 1'b1;
      M_TXP_WR, M_TXP_RD, M_RXP_RD:
        ptr_inc = (ptr_q == PTR_W'(PAY_DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      M_TXA_WR, M_TXA_RD:
        ptr_inc = (ptr_q == PTR_W'(TXA_DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      default:
        ptr_inc = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_CMD;
      ptr_q  <= '0;
    end else if (!active) begin
      mode_q <= M_CMD;
      ptr_q  <= '0;
    end else if (cmd_phase) begin
      mode_q <= op_mode;
      ptr_q  <= (op_mode == M_CFG_WR || op_mode == M_CFG_RD) ?
                PTR_W'(rx_byte[3:0]) : '0;
    end else if (data_phase) begin
      ptr_q <= ptr_inc;
      if (mode_q == M_CHAN) mode_q <= M_DONE;
    end
  end

  // Configuration file
  logic             cfg_we, chan_en;
  logic [PTR_W-1:0] cfg_waddr;
  logic [7:0]       cfg_rdata;

  assign cfg_we    = data_phase && (mode_q == M_CFG_WR || mode_q == M_CHAN);
  assign cfg_waddr = (mode_q == M_CHAN) ? PTR_W'(CHAN_LO_IDX) : ptr_q;
  assign chan_en   = cmd_phase && (op_mode == M_CHAN);

  radio_cfg_file #(.ADDR_W(PTR_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_addr  (cfg_waddr),
    .wr_data  (rx_byte),
    .chan_en  (chan_en),
    .chan_bits(rx_byte[3:0]),
    .rd_addr  (ptr_q),
    .rd_data  (cfg_rdata)
  );

  // Buffers
  logic       txp_we, txa_we, rxp_we;
  logic [7:0] txp_rdata, txa_rdata, rxp_rdata;

  assign txp_we        = data_phase && (mode_q == M_TXP_WR);
  assign txa_we        = data_phase && (mode_q == M_TXA_WR);
  assign rx_load_ready = !active;
  assign rxp_we        = rx_load_valid && rx_load_ready;

  radio_byte_ram #(.DEPTH(PAY_DEPTH)) u_txp (
    .clk  (clk),
    .we   (txp_we),
    .waddr(ptr_q[PAY_IW-1:0]),
    .wdata(rx_byte),
    .raddr(ptr_q[PAY_IW-1:0]),
    .rdata(txp_rdata)
  );

  radio_byte_ram #(.DEPTH(TXA_DEPTH)) u_txa (
    .clk  (clk),
    .we   (txa_we),
    .waddr(ptr_q[TXA_IW-1:0]),
    .wdata(rx_byte),
    .raddr(ptr_q[TXA_IW-1:0]),
    .rdata(txa_rdata)
  );

  radio_byte_ram #(.DEPTH(PAY_DEPTH)) u_rxp (
    .clk  (clk),
    .we   (rxp_we),
    .waddr(rx_wptr),
    .wdata(rx_load_data),
    .raddr(ptr_q[PAY_IW-1:0]),
    .rdata(rxp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_wptr <= '0;
    else if (rxp_we)
      rx_wptr <= (rx_wptr == PAY_IW'(PAY_DEPTH - 1)) ? '0 : rx_wptr + 1'b1;
  end

  always_comb begin
    case (mode_q)
      M_CFG_RD: tx_byte = cfg_rdata;
      M_TXP_RD: tx_byte = txp_rdata;
      M_TXA_RD: tx_byte = txa_rdata;
      M_RXP_RD: tx_byte = rxp_rdata;
      default:  tx_byte = '0;
    endcase
  end

  assert_pay_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && data_phase && (mode_q == M_TXP_WR || mode_q == M_TXP_RD) &&
     ptr_q == PTR_W'(PAY_DEPTH - 1)) |=> (ptr_q == '0));

  assert_txa_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && data_phase && (mode_q == M_TXA_WR || mode_q == M_TXA_RD) &&
     ptr_q == PTR_W'(TXA_DEPTH - 1)) |=> (ptr_q == '0));

  assert_rxload_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load_valid && rx_load_ready) |=>
      (rx_wptr == (($past(rx_wptr) == PAY_IW'(PAY_DEPTH - 1)) ? '0 : $past(rx_wptr) + 1'b1)));

  assert_ignore_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DONE) |-> !(cfg_we || txp_we || txa_we || chan_en));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (mode_q == M_CMD));

endmodule

// File: tb/radio_spi_cmd_bench.sv
`timescale 1ns/1ps
module radio_spi_cmd_bench;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic am = 1'b0, dr = 1'b0;
  logic ld_valid = 1'b0;
  logic ld_ready;
  logic [7:0] ld_data = '0;

  always #4 clk = ~clk;

  radio_spi_cmd u_radio_spi_cmd (
    .clk            (clk),
    .rst_n          (rst_n),
    .spi_sclk       (sclk),
    .spi_cs_n       (cs_n),
    .spi_mosi       (mosi),
    .spi_miso       (miso),
    .flag_addr_match(am),
    .flag_data_ready(dr),
    .rx_load_valid  (ld_valid),
    .rx_load_ready  (ld_ready),
    .rx_load_data   (ld_data)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] cfg_m [10];
  logic [7:0] txp_m [32];
  logic [7:0] txa_m [4];
  logic [7:0] rxp_m [32];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat();
    return {am, 1'b0, dr, 5'b0};
  endfunction

  // Monitor: assembles MISO bytes on SCLK rising edges and scores them.
  initial begin
    logic [7:0] cap;
    int nb;
    cap = '0; nb = 0;
    forever begin
      @(posedge sclk or posedge cs_n);
      if (cs_n) nb = 0;
      else begin
        cap = {cap[6:0], miso};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) chk(1'b0, "scoreboard-empty", cap, 0);
          else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(cap === e, t, cap, e);
          end
        end
      end
    end
  end

  task automatic cs_begin();
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (3*H) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] mo, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = mo[i];
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] mo, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    spi_bits(mo, 8);
  endtask

  task automatic read_cfg(input int start, input int n, input string tag);
    cs_begin();
    spi_byte(8'h10 | 8'(start), stat(), "R1");
    for (int i = 0; i < n; i++)
      spi_byte(8'h00, (start + i < 10) ? cfg_m[start + i] : 8'h00, tag);
    cs_end();
  endtask

  task automatic write_cfg(input int start, input int n, input logic [7:0] base);
    cs_begin();
    spi_byte(8'h00 | 8'(start), stat(), "R1");
    for (int i = 0; i < n; i++) begin
      spi_byte(base + 8'(i * 17), 8'h00, "R9");
      if (start + i < 10) cfg_m[start + i] = base + 8'(i * 17);
    end
    cs_end();
  endtask

  initial begin
    for (int i = 0; i < 10; i++) cfg_m[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state at the ports
    chk(miso === 1'b0, "R11 miso idle", miso, 0);
    chk(ld_ready === 1'b1, "R11 ready idle", ld_ready, 1);

    // R8: fill RX buffer through the stream port
    for (int i = 0; i < 32; i++) begin
      rxp_m[i] = 8'hA0 ^ 8'(i * 5);
      ld_valid = 1'b1;
      ld_data  = rxp_m[i];
      @(negedge clk);
    end
    ld_valid = 1'b0;

    // R11 / R1 / R4: reset config reads as 0, past the end too
    am = 1'b1; dr = 1'b0;
    read_cfg(0, 12, "R11 R4 cfg reset");

    // R2 / R3: full write then read back, different status pattern
    am = 1'b0; dr = 1'b1;
    write_cfg(0, 10, 8'h11);
    cfg_m[1] = 8'h32;
    cs_begin(); spi_byte(8'h01, stat(), "R1"); spi_byte(8'h32, 8'h00, "R9"); cs_end();
    read_cfg(0, 10, "R3 cfg readback");

    // R2 / R4: mid start, then start near the end (drops past 9)
    am = 1'b1; dr = 1'b1;
    write_cfg(3, 3, 8'h5C);
    read_cfg(3, 3, "R2 mid write");
    write_cfg(8, 4, 8'hC3);
    read_cfg(7, 5, "R4 tail read");
    write_cfg(12, 3, 8'hEE);
    read_cfg(0, 10, "R4 start above 9");
    read_cfg(13, 2, "R4 read start above 9");

    // R5: channel command
    am = 1'b0; dr = 1'b0;
    cs_begin();
    spi_byte(8'h8D, stat(), "R1");
    spi_byte(8'h5A, 8'h00, "R9");
    spi_byte(8'h99, 8'h00, "R5 extra ignored");
    cs_end();
    cfg_m[0] = 8'h5A;
    cfg_m[1] = (cfg_m[1] & 8'hF0) | 8'h0D;
    read_cfg(0, 3, "R5 channel fields");

    // R6: TX payload with write wrap and read wrap
    cs_begin();
    spi_byte(8'h20, stat(), "R1");
    for (int i = 0; i < 34; i++) begin
      logic [7:0] v;
      v = 8'h3C + 8'(i * 7);
      spi_byte(v, 8'h00, "R9");
      txp_m[i % 32] = v;
    end
    cs_end();
    cs_begin();
    spi_byte(8'h21, stat(), "R1");
    for (int i = 0; i < 34; i++) spi_byte(8'h00, txp_m[i % 32], "R6 payload");
    cs_end();

    // R7: TX address buffer with wrap
    cs_begin();
    spi_byte(8'h22, stat(), "R1");
    for (int i = 0; i < 5; i++) begin
      spi_byte(8'hD0 + 8'(i), 8'h00, "R9");
      txa_m[i % 4] = 8'hD0 + 8'(i);
    end
    cs_end();
    cs_begin();
    spi_byte(8'h23, stat(), "R1");
    for (int i = 0; i < 6; i++) spi_byte(8'h00, txa_m[i % 4], "R7 address");
    cs_end();

    // R8: RX read, blocked load during the frame
    cs_begin();
    chk(ld_ready === 1'b0, "R8 ready low in frame", ld_ready, 0);
    ld_valid = 1'b1; ld_data = 8'hEE;
    repeat (4) @(negedge clk);
    ld_valid = 1'b0;
    spi_byte(8'h24, stat(), "R1");
    for (int i = 0; i < 33; i++) spi_byte(8'h00, rxp_m[i % 32], "R8 rx payload");
    cs_end();

    // R9: unknown opcode
    cs_begin();
    spi_byte(8'h30, stat(), "R1");
    spi_byte(8'h07, 8'h00, "R9 unknown");
    spi_byte(8'h08, 8'h00, "R9 unknown");
    cs_end();
    read_cfg(0, 10, "R9 cfg kept");

    // R10: abort mid data byte and mid opcode
    cs_begin();
    spi_byte(8'h00, stat(), "R1");
    spi_bits(8'hFF, 4);
    cs_end();
    cs_begin();
    spi_bits(8'h05, 5);
    cs_end();
    am = 1'b1;
    read_cfg(0, 2, "R10 after abort");
    cs_begin();
    spi_byte(8'h03, stat(), "R1");
    cs_end();
    cs_begin();
    spi_byte(8'h13, stat(), "R10 new frame opcode");
    spi_byte(8'h00, cfg_m[3], "R10 new frame data");
    cs_end();
    chk(miso === 1'b0, "R11 miso idle after frames", miso, 0);

    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule